// File: doc/BRIEF.md
# Pipelined Control-Word Carrier

This block moves the control information of each instruction down a five-stage in-order pipeline, so that every stage finds its own control signals in its own pipeline register. An instruction enters with a valid flag, a 3-bit opcode and a destination register number. It is latched into the decode register. A main decoder reads it there once and produces the full control bundle. The bundle then moves forward one register per clock. At each step the groups that are already used are dropped, so the execute register carries all groups, the memory register carries the memory and writeback groups, and the writeback register carries only the writeback group.

Every pipeline register also keeps the valid flag, the opcode and the destination register of its instruction. The hazard logic around the block asserts two inputs. A stall holds the decode register and sends a bubble into execute. A per-stage flush clears the valid flag of the addressed register. A register whose valid flag is clear drives all-zero controls, so no register write and no memory write can come from it. Every output comes straight from a flip-flop.

Top module: `dstat_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the valid flag, opcode, destination and all controls of every stage register. These stay zero until the first load after reset.
- R2: With no stall and no flush, the fetch-side valid, opcode and destination appear on the decode-stage outputs one clock edge after they are presented.
- R3: The decoder uses these opcodes: 0 load, 1 store, 2 register ALU, 3 immediate ALU, 4 branch. The ALU op codes are 0 add, 1 subtract, 2 function field, 3 OR. The controls are (sign-extend, immediate source, ALU op, dest-is-rd, memory write, branch, memory-to-register, register write). Load gives (1,1,0,0,0,0,1,1). Store gives (1,1,0,0,1,0,0,0). Register ALU gives (0,0,2,1,0,0,0,1). Immediate ALU gives (0,1,3,0,0,0,0,1). Branch gives (1,0,1,0,0,1,0,0).
- R4: Execute-stage controls, opcode and destination of an instruction appear one cycle after it sits in decode.
- R5: Memory-stage controls (memory write, branch) appear two cycles after decode.
- R6: Writeback controls (memory-to-register, register write) and the destination appear three cycles after decode.
- R7: While the stall input is high, the decode register holds its contents and the execute register loads a bubble (valid low). The memory and writeback registers keep advancing.
- R8: Flush input bit 0, 1, 2 or 3 makes the decode, execute, memory or writeback register, respectively, become invalid at the next edge.
- R9: When stall and flush bit 0 are both high, the decode register becomes invalid instead of holding.
- R10: A stage whose valid flag is low drives zero on every control, opcode and destination output; in particular its register-write and memory-write outputs are low.
- R11: Opcodes 5 to 7 travel as valid instructions with all controls zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Instruction offered to decode is real |
| fetch_op_i | input | 3 | Opcode offered to decode |
| fetch_rd_i | input | REG_W | Destination register offered to decode |
| stall_i | input | 1 | Hold decode, bubble into execute |
| flush_i | input | 4 | Per-stage invalidate: bit0 decode, bit1 execute, bit2 memory, bit3 writeback |
| id_valid_o | output | 1 | Decode register valid |
| id_op_o | output | 3 | Decode register opcode |
| id_rd_o | output | REG_W | Decode register destination |
| ex_valid_o | output | 1 | Execute register valid |
| ex_op_o | output | 3 | Execute register opcode |
| ex_rd_o | output | REG_W | Execute register destination |
| ex_ext_sign_o | output | 1 | Sign-extend the immediate |
| ex_src_imm_o | output | 1 | ALU second operand is the immediate |
| ex_alu_op_o | output | 2 | ALU operation code |
| ex_dst_rd_o | output | 1 | Destination taken from the rd field |
| mem_valid_o | output | 1 | Memory register valid |
| mem_op_o | output | 3 | Memory register opcode |
| mem_rd_o | output | REG_W | Memory register destination |
| mem_wr_o | output | 1 | Data memory write |
| mem_branch_o | output | 1 | Branch decision enable |
| wb_valid_o | output | 1 | Writeback register valid |
| wb_op_o | output | 3 | Writeback register opcode |
| wb_rd_o | output | REG_W | Writeback register destination |
| wb_mem_to_reg_o | output | 1 | Write data comes from memory |
| wb_reg_wr_o | output | 1 | Register file write |

## Verification
The first stream sends all eight opcodes back to back with no hazards. It shows whether each control group surfaces in the right stage and in the right cycle, and whether the unused opcodes decode to zero. Runs with random stalls tell a correct hold-and-bubble from a design that drops or duplicates an instruction. Runs with random flush masks and random fetch gaps show whether an invalid stage still leaks a write. Cycles with stall and decode flush together tell which of the two wins. A reset in the middle of traffic shows that every stage clears at once.

// File: rtl/dstat_pkg.sv
package dstat_pkg;

  localparam int OP_W     = 3;
  localparam int N_STAGES = 4;  // decode, execute, memory, writeback registers

  localparam logic [OP_W-1:0] OPC_LOAD   = 3'd0;
  localparam logic [OP_W-1:0] OPC_STORE  = 3'd1;
  localparam logic [OP_W-1:0] OPC_ALU_R  = 3'd2;
  localparam logic [OP_W-1:0] OPC_ALU_I  = 3'd3;
  localparam logic [OP_W-1:0] OPC_BRANCH = 3'd4;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_SUB  = 2'd1,
    ALU_FUNC = 2'd2,
    ALU_OR   = 2'd3
  } alu_e;

  typedef struct packed {
    logic ext_sign;
    logic src_imm;
    alu_e alu_op;
    logic dst_rd;
  } ex_grp_t;

  typedef struct packed {
    logic mem_wr;
    logic branch;
  } mem_grp_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_grp_t;

  typedef struct packed {
    ex_grp_t  ex;
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctrl_t;

endpackage

// File: rtl/dstat_decoder.sv
module dstat_decoder
  import dstat_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    case (op_i)
      OPC_LOAD: begin
        ctrl_o.ex.ext_sign   = 1'b1;
        ctrl_o.ex.src_imm    = 1'b1;
        ctrl_o.ex.alu_op     = ALU_ADD;
        ctrl_o.wb.mem_to_reg = 1'b1;
        ctrl_o.wb.reg_wr     = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.ex.ext_sign = 1'b1;
        ctrl_o.ex.src_imm  = 1'b1;
        ctrl_o.ex.alu_op   = ALU_ADD;
        ctrl_o.mem.mem_wr  = 1'b1;
      end
      OPC_ALU_R: begin
        ctrl_o.ex.alu_op  = ALU_FUNC;
        ctrl_o.ex.dst_rd  = 1'b1;
        ctrl_o.wb.reg_wr  = 1'b1;
      end
      OPC_ALU_I: begin
        ctrl_o.ex.src_imm = 1'b1;
        ctrl_o.ex.alu_op  = ALU_OR;
        ctrl_o.wb.reg_wr  = 1'b1;
      end
      OPC_BRANCH: begin
        ctrl_o.ex.ext_sign = 1'b1;
        ctrl_o.ex.alu_op   = ALU_SUB;
        ctrl_o.mem.branch  = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/dstat_stage.sv
module dstat_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_i,
  input  logic         kill_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (kill_i) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (!hold_i) begin
      valid_o <= valid_i;
      data_o  <= valid_i ? data_i : '0;
    end
  end

  a_r8_kill_invalidates: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> !valid_o);

  a_r7_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !kill_i) |=> ($stable(valid_o) && $stable(data_o)));

  a_r10_idle_is_zero: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (data_o == '0));

endmodule

// File: rtl/dstat_ctrl.sv
module dstat_ctrl
  import dstat_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_valid_i,
  input  logic [OP_W-1:0]     fetch_op_i,
  input  logic [REG_W-1:0]    fetch_rd_i,
  input  logic                stall_i,
  input  logic [N_STAGES-1:0] flush_i,
  output logic                id_valid_o,
  output logic [OP_W-1:0]     id_op_o,
  output logic [REG_W-1:0]    id_rd_o,
  output logic                ex_valid_o,
  output logic [OP_W-1:0]     ex_op_o,
  output logic [REG_W-1:0]    ex_rd_o,
  output logic                ex_ext_sign_o,
  output logic                ex_src_imm_o,
  output logic [1:0]          ex_alu_op_o,
  output logic                ex_dst_rd_o,
  output logic                mem_valid_o,
  output logic [OP_W-1:0]     mem_op_o,
  output logic [REG_W-1:0]    mem_rd_o,
  output logic                mem_wr_o,
  output logic                mem_branch_o,
  output logic                wb_valid_o,
  output logic [OP_W-1:0]     wb_op_o,
  output logic [REG_W-1:0]    wb_rd_o,
  output logic                wb_mem_to_reg_o,
  output logic                wb_reg_wr_o
);

  localparam int TAG_W = OP_W + REG_W;
  localparam int ID_W  = TAG_W;
  localparam int EX_W  = TAG_W + $bits(ctrl_t);
  localparam int MEM_W = TAG_W + $bits(mem_grp_t) + $bits(wb_grp_t);
  localparam int WB_W  = TAG_W + $bits(wb_grp_t);

  // decode register
  logic [ID_W-1:0] id_data;
  ctrl_t           id_ctrl;

  dstat_stage #(.W(ID_W)) u_id (
    .clk(clk), .rst(rst),
    .hold_i(stall_i), .kill_i(flush_i[0]),
    .valid_i(fetch_valid_i), .data_i({fetch_op_i, fetch_rd_i}),
    .valid_o(id_valid_o), .data_o(id_data)
  );
  assign {id_op_o, id_rd_o} = id_data;

  dstat_decoder u_dec (.op_i(id_op_o), .ctrl_o(id_ctrl));

  // execute register: whole bundle; stall sends a bubble here
  logic [EX_W-1:0] ex_data;
  ctrl_t           ex_ctrl;

  dstat_stage #(.W(EX_W)) u_ex (
    .clk(clk), .rst(rst),
    .hold_i(1'b0), .kill_i(flush_i[1] | stall_i),
    .valid_i(id_valid_o), .data_i({id_op_o, id_rd_o, id_ctrl}),
    .valid_o(ex_valid_o), .data_o(ex_data)
  );
  assign {ex_op_o, ex_rd_o, ex_ctrl} = ex_data;
  assign ex_ext_sign_o = ex_ctrl.ex.ext_sign;
  assign ex_src_imm_o  = ex_ctrl.ex.src_imm;
  assign ex_alu_op_o   = ex_ctrl.ex.alu_op;
  assign ex_dst_rd_o   = ex_ctrl.ex.dst_rd;

  // memory register: execute group dropped
  logic [MEM_W-1:0] mem_data;
  mem_grp_t         mem_grp;
  wb_grp_t          mem_wbg;

  dstat_stage #(.W(MEM_W)) u_mem (
    .clk(clk), .rst(rst),
    .hold_i(1'b0), .kill_i(flush_i[2]),
    .valid_i(ex_valid_o), .data_i({ex_op_o, ex_rd_o, ex_ctrl.mem, ex_ctrl.wb}),
    .valid_o(mem_valid_o), .data_o(mem_data)
  );
  assign {mem_op_o, mem_rd_o, mem_grp, mem_wbg} = mem_data;
  assign mem_wr_o     = mem_grp.mem_wr;
  assign mem_branch_o = mem_grp.branch;

  // writeback register: only writeback group remains
  logic [WB_W-1:0] wb_data;
  wb_grp_t         wb_grp;

  dstat_stage #(.W(WB_W)) u_wb (
    .clk(clk), .rst(rst),
    .hold_i(1'b0), .kill_i(flush_i[3]),
    .valid_i(mem_valid_o), .data_i({mem_op_o, mem_rd_o, mem_wbg}),
    .valid_o(wb_valid_o), .data_o(wb_data)
  );
  assign {wb_op_o, wb_rd_o, wb_grp} = wb_data;
  assign wb_mem_to_reg_o = wb_grp.mem_to_reg;
  assign wb_reg_wr_o     = wb_grp.reg_wr;

  // assertions
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !(id_valid_o || ex_valid_o || mem_valid_o || wb_valid_o || wb_reg_wr_o || mem_wr_o));

  a_r4_ex_follows_id: assert property (@(posedge clk) disable iff (rst)
    (id_valid_o && !stall_i && !flush_i[1]) |=> (ex_valid_o && ex_op_o == $past(id_op_o)));

  a_r5_mem_follows_ex: assert property (@(posedge clk) disable iff (rst)
    (ex_valid_o && !flush_i[2]) |=> (mem_valid_o && mem_wr_o == $past(ex_ctrl.mem.mem_wr)
                                     && mem_branch_o == $past(ex_ctrl.mem.branch)));

  a_r6_wb_follows_mem: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !flush_i[3]) |=> (wb_valid_o && wb_reg_wr_o == $past(mem_wbg.reg_wr)
                                      && wb_rd_o == $past(mem_rd_o)));

  a_r7_stall_bubbles: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> !ex_valid_o);

  a_r9_flush_beats_stall: assert property (@(posedge clk) disable iff (rst)
    (stall_i && flush_i[0]) |=> !id_valid_o);

  a_r10_no_idle_writes: assert property (@(posedge clk) disable iff (rst)
    (!wb_valid_o |-> !wb_reg_wr_o) and (!mem_valid_o |-> !mem_wr_o));

endmodule

// File: tb/dstat_ctrl_tb.sv
`timescale 1ns/1ps
module dstat_ctrl_tb_top;

  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_valid_i = 1'b0;
  logic [2:0]    fetch_op_i = '0;
  logic [RW-1:0] fetch_rd_i = '0;
  logic          stall_i = 1'b0;
  logic [3:0]    flush_i = '0;

  logic          id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o;
  logic [2:0]    id_op_o, ex_op_o, mem_op_o, wb_op_o;
  logic [RW-1:0] id_rd_o, ex_rd_o, mem_rd_o, wb_rd_o;
  logic          ex_ext_sign_o, ex_src_imm_o, ex_dst_rd_o;
  logic [1:0]    ex_alu_op_o;
  logic          mem_wr_o, mem_branch_o, wb_mem_to_reg_o, wb_reg_wr_o;

  always #2.5 clk = ~clk;

  dstat_ctrl #(.REG_W(RW)) dut_i (
    .clk(clk), .rst(rst),
    .fetch_valid_i(fetch_valid_i), .fetch_op_i(fetch_op_i), .fetch_rd_i(fetch_rd_i),
    .stall_i(stall_i), .flush_i(flush_i),
    .id_valid_o(id_valid_o), .id_op_o(id_op_o), .id_rd_o(id_rd_o),
    .ex_valid_o(ex_valid_o), .ex_op_o(ex_op_o), .ex_rd_o(ex_rd_o),
    .ex_ext_sign_o(ex_ext_sign_o), .ex_src_imm_o(ex_src_imm_o),
    .ex_alu_op_o(ex_alu_op_o), .ex_dst_rd_o(ex_dst_rd_o),
    .mem_valid_o(mem_valid_o), .mem_op_o(mem_op_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_branch_o(mem_branch_o),
    .wb_valid_o(wb_valid_o), .wb_op_o(wb_op_o), .wb_rd_o(wb_rd_o),
    .wb_mem_to_reg_o(wb_mem_to_reg_o), .wb_reg_wr_o(wb_reg_wr_o)
  );

  // reference model: index 0 decode, 1 execute, 2 memory, 3 writeback
  logic          mv  [4];
  logic [2:0]    mop [4];
  logic [RW-1:0] mrd [4];

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    chk_en = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  // expected controls {ext,imm,alu[1:0],dst_rd,memwr,branch,m2r,regwr} from R3/R11
  function automatic logic [8:0] ref_ctrl(input logic v, input logic [2:0] op);
    if (!v) return 9'd0;                         // R10
    case (op)
      3'd0: return {1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      3'd1: return {1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
      3'd2: return {1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
      3'd3: return {1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      3'd4: return {1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      default: return 9'd0;                      // R11
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 4; s++) begin mv[s] = 0; mop[s] = 0; mrd[s] = 0; end
    end else begin
      for (int s = 3; s >= 1; s--) begin
        if (flush_i[s] || (s == 1 && stall_i)) begin
          mv[s] = 0; mop[s] = 0; mrd[s] = 0;
        end else begin
          mv[s] = mv[s-1]; mop[s] = mop[s-1]; mrd[s] = mrd[s-1];
        end
      end
      if (flush_i[0]) begin
        mv[0] = 0; mop[0] = 0; mrd[0] = 0;
      end else if (!stall_i) begin
        mv[0]  = fetch_valid_i;
        mop[0] = fetch_valid_i ? fetch_op_i : 3'd0;
        mrd[0] = fetch_valid_i ? fetch_rd_i : '0;
      end
    end
  end

  task automatic check(input string grp, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s at %0t: actual %h expected %h", phase, grp, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      logic [8:0] e1, e2, e3;
      e1 = ref_ctrl(mv[1], mop[1]);
      e2 = ref_ctrl(mv[2], mop[2]);
      e3 = ref_ctrl(mv[3], mop[3]);
      check("R2 decode", {id_valid_o, id_op_o, id_rd_o}, {mv[0], mop[0], mrd[0]});
      check("R4 execute", {ex_valid_o, ex_op_o, ex_rd_o, ex_ext_sign_o, ex_src_imm_o,
                           ex_alu_op_o, ex_dst_rd_o},
                          {mv[1], mop[1], mrd[1], e1[8:4]});
      check("R5 memory", {mem_valid_o, mem_op_o, mem_rd_o, mem_wr_o, mem_branch_o},
                         {mv[2], mop[2], mrd[2], e2[3:2]});
      check("R6 writeback", {wb_valid_o, wb_op_o, wb_rd_o, wb_mem_to_reg_o, wb_reg_wr_o},
                            {mv[3], mop[3], mrd[3], e3[1:0]});
    end
  end

  task automatic step(input logic v, input logic [2:0] op, input logic st, input logic [3:0] fl);
    @(negedge clk);
    fetch_valid_i = v;
    fetch_op_i    = op;
    fetch_rd_i    = RW'($urandom_range(0, (1 << RW) - 1));
    stall_i       = st;
    flush_i       = fl;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 1'b0, 4'd0);
  endtask

  function automatic logic pct(input int p);
    return ($urandom_range(0, 99) < p);
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset state
    @(posedge clk);
    chk_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R3 R4 R5 R6 R11: all opcodes back to back, no hazards
    phase = "R3";
    for (int k = 0; k < 3; k++)
      for (int op = 0; op < 8; op++) step(1'b1, 3'(op), 1'b0, 4'd0);
    quiet(5);

    // R7: random stalls
    phase = "R7";
    for (int i = 0; i < 200; i++) step(1'b1, 3'($urandom_range(0, 4)), pct(35), 4'd0);
    quiet(5);

    // R8: random flush masks
    phase = "R8";
    for (int i = 0; i < 200; i++)
      step(1'b1, 3'($urandom_range(0, 4)), 1'b0, pct(40) ? 4'($urandom_range(1, 15)) : 4'd0);
    quiet(5);

    // R9: stall and decode flush together
    phase = "R9";
    for (int i = 0; i < 100; i++) step(1'b1, 3'($urandom_range(0, 4)), pct(60), {3'd0, pct(50)});
    quiet(5);

    // R10: fetch gaps plus flushes, idle stages must not write
    phase = "R10";
    for (int i = 0; i < 200; i++)
      step(pct(50), 3'($urandom_range(0, 7)), pct(20), pct(20) ? 4'($urandom_range(1, 15)) : 4'd0);
    quiet(5);

    // R11: only undefined opcodes
    phase = "R11";
    for (int i = 0; i < 40; i++) step(1'b1, 3'($urandom_range(5, 7)), 1'b0, 4'd0);
    quiet(5);

    // R1: reset in the middle of traffic
    phase = "R1";
    for (int i = 0; i < 6; i++) step(1'b1, 3'($urandom_range(0, 4)), 1'b0, 4'd0);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // mixed traffic
    phase = "R2";
    for (int i = 0; i < 1000; i++)
      step(pct(80), 3'($urandom_range(0, 7)), pct(20), pct(15) ? 4'($urandom_range(1, 15)) : 4'd0);
    quiet(6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule